// File: doc/BRIEF.md
# Wake Interrupt Aggregation Controller

This block collects the interrupt sources that may wake a sleeping system into one map of 64 top-level bits and raises a single wake request whenever any enabled bit has a live source. Bit 0 carries the output of an external non-maskable-interrupt latch. Bits 1 to 18 carry direct interrupt lines: 1 to 15 come from ordinary peripherals, and 16 to 18 come from peripherals with banked interrupts. From bit 19 upward, each top-level bit is the OR of a group of eight muxed lines. Each muxed line has its own mux-enable bit that gates it first.

Software uses a small register port to program the top-level enable words and the 128 mux-enable bits before entering sleep. It can read the masked pending value of every top-level bit through the same port. A configuration mask sets which muxed lines exist in a given build. Mux-enable bits for absent lines cannot be set, and those lines never reach the pending map. Reads are combinational on the address. Writes take effect at the clock edge. Source lines are sampled once per clock, so a change on an input shows in the pending value one cycle later.

Top module: `wake_agg_ctrl`

## Requirements
- R1: After reset, every enable word and mux-enable word reads 0, every pending word reads 0 and `wake_o` is low.
- R2: The two enable words sit at byte addresses 0x40 (bits 31:0) and 0x44 (bits 63:32). A write stores all 32 bits, and a read returns them.
- R3: The four mux-enable words sit at 0xC0, 0xC4, 0xC8 and 0xCC. Word n holds mux-enable bits 32n+31 down to 32n, and a read returns the stored bits.
- R4: A mux line whose bit in the validity mask is 0 has no usable mux-enable bit. Writes to that bit are dropped, it reads 0, and its input never affects pending or wake. The default mask is 0x0000000F_FFFFFFFF_FFF80000_FFFFFFFF, with word 3 first.
- R5: Top-level bit 0 follows `nmi_i`, and top-level bit k (1 to 18) follows `direct_irq_i[k-1]`. Each is ANDed with enable bit k and becomes visible one clock after the input is sampled.
- R6: Top-level bit 19+g is the OR over i = 0..7 of `mux_irq_i[8g+i]` AND mux-enable bit 8g+i. That result is ANDed with enable bit 19+g.
- R7: The pending words at 0x10 (bits 31:0) and 0x14 (bits 63:32) are read-only. Writes to them leave the read value unchanged.
- R8: `wake_o` is 1 exactly when at least one readable pending bit is 1.
- R9: Top-level bits above the last mux group (35 to 63 by default) have no source and read 0 in the pending words even when they are enabled.
- R10: Any address outside the pending, enable and mux-enable words reads 0, and a write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Output of the external NMI latch (top-level bit 0) |
| direct_irq_i | input | 18 | Direct lines for top-level bits 1 to 18 |
| mux_irq_i | input | 128 | Muxed lines, eight per top-level bit from 19 up |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte address for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| wake_o | output | 1 | Aggregated wake request |

## Verification
The bench drives lines in the invalid mux range (line 40) next to valid lines in the same word. It also writes all ones to the mux-enable words. A design that skipped the validity mask would read back extra bits and show a stray top-level bit 24. Group 6 mixes invalid and valid lines, and line 53 is chosen to catch a group index that is off by one or computed as m mod 8. Writes to the pending words and to unmapped addresses are followed by reads that show the state did not move. A design that let those writes store anything would return non-zero data. The enabled-but-unsourced upper word and the sequence that clears enable while a source stays high expose a wake output that ignores the enable mask.

// File: rtl/wake_agg_pkg.sv
package wake_agg_pkg;
    // Register map byte offsets (word stride of 4)
    localparam int unsigned PEND_BASE  = 32'h10;
    localparam int unsigned EN_BASE    = 32'h40;
    localparam int unsigned MUXEN_BASE = 32'hC0;

    // Default existence mask for the 128 muxed lines, word 3 first
    localparam logic [127:0] DEFAULT_MUX_VALID =
        {32'h0000_000F, 32'hFFFF_FFFF, 32'hFFF8_0000, 32'hFFFF_FFFF};
endpackage

// File: rtl/wake_src_gather.sv
module wake_src_gather #(
    parameter int unsigned TOP_BITS   = 64,
    parameter int unsigned NUM_DIRECT = 18,
    parameter int unsigned MUX_BITS   = 128,
    parameter int unsigned GROUP_SIZE = 8,
    parameter int unsigned MUX_BASE   = 19,
    parameter logic [MUX_BITS-1:0] MUX_VALID = '1
) (
    input  logic                  nmi_i,
    input  logic [NUM_DIRECT-1:0] direct_i,
    input  logic [MUX_BITS-1:0]   mux_i,
    input  logic [MUX_BITS-1:0]   muxen_i,
    output logic [TOP_BITS-1:0]   src_o
);
    localparam int unsigned GROUPS   = MUX_BITS / GROUP_SIZE;
    localparam int unsigned MUX_LAST = MUX_BASE + GROUPS;

    // Gated muxed lines: both enable and existence are required
    logic [MUX_BITS-1:0] mux_gated;
    assign mux_gated = mux_i & muxen_i & MUX_VALID;

    assign src_o[0] = nmi_i;
    assign src_o[NUM_DIRECT:1] = direct_i;

    if (MUX_BASE > NUM_DIRECT + 1) begin : g_gap
        assign src_o[MUX_BASE-1:NUM_DIRECT+1] = '0;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        assign src_o[MUX_BASE+g] = |mux_gated[g*GROUP_SIZE +: GROUP_SIZE];
    end

    if (TOP_BITS > MUX_LAST) begin : g_unsourced
        assign src_o[TOP_BITS-1:MUX_LAST] = '0;
    end
endmodule

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs #(
    parameter int unsigned TOP_BITS   = 64,
    parameter int unsigned MUX_BITS   = 128,
    parameter int unsigned AW         = 8,
    parameter int unsigned EN_BASE    = 32'h40,
    parameter int unsigned MUXEN_BASE = 32'hC0,
    parameter logic [MUX_BITS-1:0] MUX_VALID = '1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                we_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [31:0]         wdata_i,
    output logic [TOP_BITS-1:0] en_o,
    output logic [MUX_BITS-1:0] muxen_o
);
    localparam int unsigned EN_WORDS  = TOP_BITS / 32;
    localparam int unsigned MUX_WORDS = MUX_BITS / 32;

    typedef struct packed {
        logic [TOP_BITS-1:0] en;
        logic [MUX_BITS-1:0] muxen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            for (int w = 0; w < EN_WORDS; w++) begin
                if (addr_i == AW'(EN_BASE + 4 * w))
                    cfg_d.en[w*32 +: 32] = wdata_i;
            end
            for (int w = 0; w < MUX_WORDS; w++) begin
                if (addr_i == AW'(MUXEN_BASE + 4 * w))
                    cfg_d.muxen[w*32 +: 32] = wdata_i & MUX_VALID[w*32 +: 32];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign en_o    = cfg_q.en;
    assign muxen_o = cfg_q.muxen;

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (cfg_q.en == '0 && cfg_q.muxen == '0));

    assert_en_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == AW'(EN_BASE)) |=> (cfg_q.en[31:0] == $past(wdata_i)));

    assert_invalid_mux_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.muxen & ~MUX_VALID) == '0);
endmodule

// File: rtl/wake_rd_mux.sv
module wake_rd_mux #(
    parameter int unsigned TOP_BITS   = 64,
    parameter int unsigned MUX_BITS   = 128,
    parameter int unsigned AW         = 8,
    parameter int unsigned PEND_BASE  = 32'h10,
    parameter int unsigned EN_BASE    = 32'h40,
    parameter int unsigned MUXEN_BASE = 32'hC0
) (
    input  logic [AW-1:0]       addr_i,
    input  logic [TOP_BITS-1:0] pend_i,
    input  logic [TOP_BITS-1:0] en_i,
    input  logic [MUX_BITS-1:0] muxen_i,
    output logic [31:0]         rdata_o
);
    localparam int unsigned EN_WORDS  = TOP_BITS / 32;
    localparam int unsigned MUX_WORDS = MUX_BITS / 32;

    always_comb begin
        rdata_o = '0;
        for (int w = 0; w < EN_WORDS; w++) begin
            if (addr_i == AW'(PEND_BASE + 4 * w)) rdata_o = pend_i[w*32 +: 32];
            if (addr_i == AW'(EN_BASE + 4 * w))   rdata_o = en_i[w*32 +: 32];
        end
        for (int w = 0; w < MUX_WORDS; w++) begin
            if (addr_i == AW'(MUXEN_BASE + 4 * w)) rdata_o = muxen_i[w*32 +: 32];
        end
    end
endmodule

// File: rtl/wake_agg_ctrl.sv
module wake_agg_ctrl
    import wake_agg_pkg::*;
#(
    parameter int unsigned TOP_BITS   = 64,
    parameter int unsigned NUM_DIRECT = 18,
    parameter int unsigned MUX_BITS   = 128,
    parameter int unsigned GROUP_SIZE = 8,
    parameter int unsigned MUX_BASE   = 19,
    parameter int unsigned AW         = 8,
    parameter logic [MUX_BITS-1:0] MUX_VALID = DEFAULT_MUX_VALID
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  nmi_i,
    input  logic [NUM_DIRECT-1:0] direct_irq_i,
    input  logic [MUX_BITS-1:0]   mux_irq_i,
    input  logic                  reg_we_i,
    input  logic [AW-1:0]         reg_addr_i,
    input  logic [31:0]           reg_wdata_i,
    output logic [31:0]           reg_rdata_o,
    output logic                  wake_o
);
    localparam int unsigned MUX_LAST = MUX_BASE + MUX_BITS / GROUP_SIZE;

    typedef struct packed {
        logic [TOP_BITS-1:0] src;
    } samp_t;

    samp_t samp_d, samp_q;

    logic [TOP_BITS-1:0] src_w;
    logic [TOP_BITS-1:0] en_w;
    logic [MUX_BITS-1:0] muxen_w;
    logic [TOP_BITS-1:0] pend_w;

    wake_cfg_regs #(
        .TOP_BITS(TOP_BITS), .MUX_BITS(MUX_BITS), .AW(AW),
        .EN_BASE(EN_BASE), .MUXEN_BASE(MUXEN_BASE), .MUX_VALID(MUX_VALID)
    ) cfg_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .en_o(en_w), .muxen_o(muxen_w)
    );

    wake_src_gather #(
        .TOP_BITS(TOP_BITS), .NUM_DIRECT(NUM_DIRECT), .MUX_BITS(MUX_BITS),
        .GROUP_SIZE(GROUP_SIZE), .MUX_BASE(MUX_BASE), .MUX_VALID(MUX_VALID)
    ) gather_i (
        .nmi_i(nmi_i), .direct_i(direct_irq_i), .mux_i(mux_irq_i),
        .muxen_i(muxen_w), .src_o(src_w)
    );

    always_comb begin
        samp_d     = samp_q;
        samp_d.src = src_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) samp_q <= '0;
        else         samp_q <= samp_d;
    end

    assign pend_w = samp_q.src & en_w;
    assign wake_o = |pend_w;

    wake_rd_mux #(
        .TOP_BITS(TOP_BITS), .MUX_BITS(MUX_BITS), .AW(AW),
        .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE), .MUXEN_BASE(MUXEN_BASE)
    ) rd_i (
        .addr_i(reg_addr_i), .pend_i(pend_w), .en_i(en_w),
        .muxen_i(muxen_w), .rdata_o(reg_rdata_o)
    );

    assert_nmi_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (samp_q.src[0] == $past(nmi_i)));

    assert_wake_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> (|en_w));

    if (TOP_BITS > MUX_LAST) begin : g_chk_unsourced
        assert_unsourced_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            pend_w[TOP_BITS-1:MUX_LAST] == '0);
    end
endmodule

// File: tb/wake_agg_ctrl_tb_top.sv
module wake_agg_ctrl_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         nmi = 1'b0;
    logic [17:0]  direct = '0;
    logic [127:0] mux = '0;
    logic         we = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    wake_agg_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .direct_irq_i(direct),
        .mux_irq_i(mux), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wake_o(wake)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, exp);
        end
    endtask

    task automatic wake_chk(input logic exp, input string req);
        #1;
        checks++;
        if (wake !== exp) begin
            errors++;
            $display("FAIL %s wake actual=%b expected=%b", req, wake, exp);
        end
    endtask

    // Apply inputs at a falling edge, let one rising edge sample them
    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk(8'h40, 32'h0, "R1");
        rd_chk(8'h44, 32'h0, "R1");
        for (int w = 0; w < 4; w++) rd_chk(8'hC0 + 8'(4 * w), 32'h0, "R1");
        rd_chk(8'h10, 32'h0, "R1");
        rd_chk(8'h14, 32'h0, "R1");
        wake_chk(1'b0, "R1");
    endtask

    task automatic t_enable_rw();
        wr(8'h40, 32'hA5A5_5A5A);
        wr(8'h44, 32'h1234_5678);
        rd_chk(8'h40, 32'hA5A5_5A5A, "R2");
        rd_chk(8'h44, 32'h1234_5678, "R2");
    endtask

    task automatic t_mux_rw();
        for (int w = 0; w < 4; w++) wr(8'hC0 + 8'(4 * w), 32'hFFFF_FFFF);
        rd_chk(8'hC0, 32'hFFFF_FFFF, "R3");
        rd_chk(8'hC4, 32'hFFF8_0000, "R4");
        rd_chk(8'hC8, 32'hFFFF_FFFF, "R3");
        rd_chk(8'hCC, 32'h0000_000F, "R4");
    endtask

    task automatic t_direct();
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        @(negedge clk);
        nmi = 1'b1; direct[4] = 1'b1; direct[16] = 1'b1;
        settle();
        rd_chk(8'h10, 32'h0002_0021, "R5");
        wr(8'h40, 32'hFFFF_FFDF);
        rd_chk(8'h10, 32'h0002_0001, "R5");
        @(negedge clk);
        nmi = 1'b0; direct = '0;
        settle();
        rd_chk(8'h10, 32'h0, "R5");
    endtask

    task automatic t_mux();
        wr(8'h40, 32'hFFFF_FFFF);
        @(negedge clk);
        mux[3] = 1'b1; mux[53] = 1'b1; mux[99] = 1'b1; mux[40] = 1'b1;
        settle();
        rd_chk(8'h10, 32'h8208_0000, "R6"); // bit 24 absent: R4
        @(negedge clk);
        mux[64] = 1'b1;
        settle();
        rd_chk(8'h10, 32'h8A08_0000, "R6");
        wr(8'hC0, 32'h0);
        @(negedge clk);
        rd_chk(8'h10, 32'h8A00_0000, "R6");
        rd_chk(8'hC0, 32'h0, "R3");
        @(negedge clk);
        mux = '0;
        settle();
        rd_chk(8'h10, 32'h0, "R6");
    endtask

    task automatic t_unsourced();
        wr(8'hC0, 32'hFFFF_FFFF);
        @(negedge clk);
        nmi = 1'b1; direct = '1; mux = '1;
        settle();
        rd_chk(8'h10, 32'hFE7F_FFFF, "R4");
        rd_chk(8'h14, 32'h0, "R9");
        @(negedge clk);
        nmi = 1'b0; direct = '0; mux = '0;
        settle();
    endtask

    task automatic t_pend_ro();
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h10, 32'h0, "R7");
        rd_chk(8'h14, 32'h0, "R7");
        rd_chk(8'h40, 32'hFFFF_FFFF, "R7");
    endtask

    task automatic t_wake();
        wake_chk(1'b0, "R8");
        @(negedge clk);
        direct[0] = 1'b1;
        settle();
        wake_chk(1'b1, "R8");
        wr(8'h40, 32'h0);
        wake_chk(1'b0, "R8");
        @(negedge clk);
        direct[0] = 1'b0;
        settle();
    endtask

    task automatic t_unmapped();
        wr(8'h48, 32'hFFFF_FFFF);
        wr(8'hD0, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0, "R10");
        rd_chk(8'h0C, 32'h0, "R10");
        rd_chk(8'h18, 32'h0, "R10");
        rd_chk(8'h48, 32'h0, "R10");
        rd_chk(8'hD0, 32'h0, "R10");
        rd_chk(8'h40, 32'h0, "R10");
        rd_chk(8'hC0, 32'hFFFF_FFFF, "R10");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_rw();
        t_mux_rw();
        t_direct();
        t_mux();
        t_unsourced();
        t_pend_ro();
        t_wake();
        t_unmapped();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule